// File: doc/BRIEF.md
# Descriptor Write-Commit Staging Port

This block is the write side of a descriptor queue. A wide transfer descriptor of 128 or 256 bits is built up in a staging register by a series of 32-bit bus writes. Each write selects a word by address and updates only the bytes whose byte enables are set. Software may fill the words and byte lanes in any order. The descriptor stays in the staging register until one write sets the commit bit.

The commit bit is the most significant bit of the descriptor. It sits in byte lane 3 of the highest word address. A write that sets it high merges its bytes, pushes the whole descriptor into an internal FIFO and clears the staging register. If the FIFO is full, waitrequest stalls that commit write until a consumer pops an entry. Writes that do not commit are never stalled. A consumer drains the FIFO through a valid/pop interface. The port has no read path.

Top module: `desc_commit_port`

## Requirements
- R1: After a synchronous active-low reset the FIFO is empty (`desc_valid` low), `fifo_full` and `wait_req` are low, and the staging register is all zeros.
- R2: An accepted write to word address `a` replaces byte `b` of staged bits `[32*a+8*b +: 8]` with `wr_data[8*b +: 8]` for each set `wr_be[b]`, and leaves every other staged byte unchanged.
- R3: The words and byte lanes may be written in any order. The descriptor that is pushed holds, for each byte, the value of the most recent write to it since the last commit.
- R4: A commit is a write to the top word address (`DESC_W/32 - 1`) with `wr_be[3]` set and `wr_data[31]` high. When accepted, it pushes the staged descriptor with its own bytes merged in, commit bit included.
- R5: A top-word write with bit 31 low, or with `wr_be[3]` clear, does not commit. It only updates the enabled staged bytes.
- R6: After a commit the staging register is cleared, so bytes not written before the next commit are pushed as zero.
- R7: The FIFO returns descriptors in commit order. `desc_valid` is high while it holds an entry, `desc_data` shows the oldest entry, and a `desc_pop` with `desc_valid` high removes it.
- R8: `fifo_full` is high when the FIFO holds `FIFO_DEPTH` entries. A commit write while the FIFO is full holds `wait_req` high and changes neither the staging register nor the FIFO. It completes in the first cycle the FIFO is no longer full.
- R9: A non-commit write while the FIFO is full sees `wait_req` low and is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_addr | input | $clog2(DESC_W/32) | Word address within the descriptor |
| wr_data | input | 32 | Write data |
| wr_be | input | 4 | Byte enables |
| wr_en | input | 1 | Write request |
| wait_req | output | 1 | Stall; the write is not taken while high |
| fifo_full | output | 1 | FIFO holds FIFO_DEPTH descriptors |
| desc_valid | output | 1 | FIFO holds at least one descriptor |
| desc_data | output | DESC_W | Oldest queued descriptor |
| desc_pop | input | 1 | Remove the oldest descriptor |

## Verification
The assertions assume two things about the inputs. The consumer pops only while `desc_valid` is high. A master that sees `wait_req` keeps its write stable until the write is taken. The bench keeps to both: it pops only after it has checked `desc_valid`, and it holds a stalled commit unchanged for every cycle of the stall. Stimulus sweeps all sixteen byte-enable patterns with word orders that vary per pattern. It also runs the FIFO to full and checks stall release against a pop.

// File: rtl/desc_pkg.sv
// Shared constants for the descriptor staging port.
// Assumes a 32-bit bus, byte-granular enables, and the commit bit in the MSB of the top word.
package desc_pkg;
    localparam int unsigned BUS_W   = 32;
    localparam int unsigned BYTE_W  = 8;
    localparam int unsigned BE_W    = BUS_W / BYTE_W;
    localparam int unsigned CMT_BIT = BUS_W - 1;
endpackage

// File: rtl/desc_commit_detect.sv
// Decodes whether the current bus write is a commit write.
// Assumes the commit bit is bit 31 of the highest word address, in byte lane 3.
module desc_commit_detect
    import desc_pkg::*;
#(
    parameter int unsigned WORDS = 8,
    localparam int unsigned AW   = $clog2(WORDS)
) (
    input  logic              wr_en_i,
    input  logic [AW-1:0]     addr_i,
    input  logic [BUS_W-1:0]  data_i,
    input  logic [BE_W-1:0]   be_i,
    output logic              commit_o
);
    localparam logic [AW-1:0] TOP_ADDR = AW'(WORDS - 1);

    // Flag a write that hits the top word with the commit lane enabled and the commit bit high.
    always_comb begin
        commit_o = wr_en_i && (addr_i == TOP_ADDR) && be_i[BE_W-1] && data_i[CMT_BIT];
    end
endmodule

// File: rtl/desc_stage.sv
// Staging register that assembles one descriptor from byte-enabled word writes.
// Assumes wr_i is high only for accepted writes and that commit_i implies wr_i.
// merged_o is the staged value with the current write applied; it is what gets pushed on commit.
module desc_stage
    import desc_pkg::*;
#(
    parameter int unsigned DESC_W = 256,
    localparam int unsigned WORDS = DESC_W / BUS_W,
    localparam int unsigned AW    = $clog2(WORDS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_i,
    input  logic [AW-1:0]     addr_i,
    input  logic [BUS_W-1:0]  data_i,
    input  logic [BE_W-1:0]   be_i,
    input  logic              commit_i,
    output logic [DESC_W-1:0] merged_o
);
    logic [DESC_W-1:0] stage_q;

    // One byte-lane mux per staged byte: take bus data where address and enable hit.
    for (genvar w = 0; w < WORDS; w++) begin : g_word
        for (genvar b = 0; b < BE_W; b++) begin : g_lane
            localparam int unsigned LSB = w * BUS_W + b * BYTE_W;
            logic hit;
            assign hit = wr_i && (addr_i == AW'(w)) && be_i[b];
            assign merged_o[LSB +: BYTE_W] = hit ? data_i[b*BYTE_W +: BYTE_W]
                                                 : stage_q[LSB +: BYTE_W];
        end
    end

    // Hold the staged bytes; clear on commit, merge on any other accepted write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stage_q <= '0;
        end else if (commit_i) begin
            stage_q <= '0;
        end else if (wr_i) begin
            stage_q <= merged_o;
        end
    end

    p_clear_after_commit_r6: assert property (@(posedge clk) disable iff (!rst_n)
        commit_i |=> (stage_q == '0));

    p_no_be_no_change_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_i && !commit_i && (be_i == '0)) |=> $stable(stage_q));
endmodule

// File: rtl/desc_fifo.sv
// Descriptor FIFO with a registered occupancy count.
// Assumes push_i is never raised while full and pop_i is never raised while empty.
module desc_fifo #(
    parameter int unsigned W     = 256,
    parameter int unsigned DEPTH = 8,
    localparam int unsigned PW   = $clog2(DEPTH),
    localparam int unsigned CW   = PW + 1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         push_i,
    input  logic [W-1:0] push_data_i,
    input  logic         pop_i,
    output logic         full_o,
    output logic         valid_o,
    output logic [W-1:0] data_o
);
    logic [W-1:0]  mem_q [DEPTH];
    logic [PW-1:0] wr_ptr_q;
    logic [PW-1:0] rd_ptr_q;
    logic [CW-1:0] count_q;

    // Status flags from the occupancy count.
    always_comb begin
        full_o  = (count_q == CW'(DEPTH));
        valid_o = (count_q != '0);
        data_o  = mem_q[rd_ptr_q];
    end

    // Write the pushed descriptor into the slot at the write pointer.
    always_ff @(posedge clk) begin
        if (push_i) begin
            mem_q[wr_ptr_q] <= push_data_i;
        end
    end

    // Advance the pointers and track occupancy.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_ptr_q <= '0;
            rd_ptr_q <= '0;
            count_q  <= '0;
        end else begin
            if (push_i) wr_ptr_q <= wr_ptr_q + 1'b1;
            if (pop_i)  rd_ptr_q <= rd_ptr_q + 1'b1;
            if (push_i && !pop_i)      count_q <= count_q + 1'b1;
            else if (pop_i && !push_i) count_q <= count_q - 1'b1;
        end
    end

    p_no_overflow_r8: assert property (@(posedge clk) disable iff (!rst_n)
        push_i |-> (count_q != CW'(DEPTH)));

    p_no_underflow_r7: assert property (@(posedge clk) disable iff (!rst_n)
        pop_i |-> (count_q != '0));

    p_count_up_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (push_i && !pop_i) |=> (count_q == $past(count_q) + 1'b1));
endmodule

// File: rtl/desc_commit_port.sv
// Write-only descriptor staging port: byte-enabled 32-bit writes build a descriptor,
// a commit write pushes it into a FIFO, and a commit into a full FIFO is stalled.
// Assumes DESC_W is 128 or 256, FIFO_DEPTH is a power of two, and a stalled master holds its write.
module desc_commit_port
    import desc_pkg::*;
#(
    parameter int unsigned DESC_W     = 256,
    parameter int unsigned FIFO_DEPTH = 8,
    localparam int unsigned WORDS     = DESC_W / BUS_W,
    localparam int unsigned AW        = $clog2(WORDS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [AW-1:0]     wr_addr,
    input  logic [BUS_W-1:0]  wr_data,
    input  logic [BE_W-1:0]   wr_be,
    input  logic              wr_en,
    output logic              wait_req,
    output logic              fifo_full,
    output logic              desc_valid,
    output logic [DESC_W-1:0] desc_data,
    input  logic              desc_pop
);
    logic              is_commit;
    logic              accept;
    logic              push;
    logic [DESC_W-1:0] merged;

    desc_commit_detect #(.WORDS(WORDS)) detect_i (
        .wr_en_i  (wr_en),
        .addr_i   (wr_addr),
        .data_i   (wr_data),
        .be_i     (wr_be),
        .commit_o (is_commit)
    );

    // Stall only a commit that would overflow; take every other write at once.
    always_comb begin
        wait_req = is_commit && fifo_full;
        accept   = wr_en && !wait_req;
        push     = accept && is_commit;
    end

    desc_stage #(.DESC_W(DESC_W)) stage_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_i     (accept),
        .addr_i   (wr_addr),
        .data_i   (wr_data),
        .be_i     (wr_be),
        .commit_i (push),
        .merged_o (merged)
    );

    desc_fifo #(.W(DESC_W), .DEPTH(FIFO_DEPTH)) fifo_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .push_i      (push),
        .push_data_i (merged),
        .pop_i       (desc_pop && desc_valid),
        .full_o      (fifo_full),
        .valid_o     (desc_valid),
        .data_o      (desc_data)
    );

    p_wait_cause_r8: assert property (@(posedge clk) disable iff (!rst_n)
        wait_req |-> (wr_en && fifo_full && wr_data[CMT_BIT]));

    p_pushed_has_commit_r4: assert property (@(posedge clk) disable iff (!rst_n)
        push |=> desc_valid);
endmodule

// File: tb/desc_commit_port_tb_top.sv
module desc_commit_port_tb_top;
    localparam int unsigned DW    = 128;
    localparam int unsigned DEPTH = 4;
    localparam int unsigned WORDS = DW / 32;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [1:0]    wr_addr = '0;
    logic [31:0]   wr_data = '0;
    logic [3:0]    wr_be = '0;
    logic          wr_en = 1'b0;
    logic          wait_req;
    logic          fifo_full;
    logic          desc_valid;
    logic [DW-1:0] desc_data;
    logic          desc_pop = 1'b0;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 1'b0;

    logic [DW-1:0] m_stage = '0;
    logic [DW-1:0] m_q [32];
    int            m_head = 0;
    int            m_tail = 0;

    always #10 clk = ~clk;

    desc_commit_port #(.DESC_W(DW), .FIFO_DEPTH(DEPTH)) dut_i (
        .clk(clk), .rst_n(rst_n), .wr_addr(wr_addr), .wr_data(wr_data), .wr_be(wr_be),
        .wr_en(wr_en), .wait_req(wait_req), .fifo_full(fifo_full),
        .desc_valid(desc_valid), .desc_data(desc_data), .desc_pop(desc_pop)
    );

    task automatic check(string tag, logic [DW-1:0] act, logic [DW-1:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Model of an accepted write (R2, R4, R6).
    task automatic model_write(int a, logic [31:0] d, logic [3:0] be);
        for (int b = 0; b < 4; b++)
            if (be[b]) m_stage[a*32 + b*8 +: 8] = d[b*8 +: 8];
        if (a == WORDS - 1 && be[3] && d[31]) begin
            m_q[m_tail % 32] = m_stage;
            m_tail++;
            m_stage = '0;
        end
    endtask

    task automatic do_write(int a, logic [31:0] d, logic [3:0] be);
        @(negedge clk);
        wr_addr = 2'(a); wr_data = d; wr_be = be; wr_en = 1'b1;
        #1;
        check("R9 wait_req on accepted write", DW'(wait_req), DW'(0));
        @(posedge clk);
        model_write(a, d, be);
        #1 wr_en = 1'b0;
    endtask

    task automatic pop_check(string tag);
        @(negedge clk);
        check({tag, " desc_valid"}, DW'(desc_valid), DW'(1));
        check({tag, " desc_data"}, desc_data, m_q[m_head % 32]);
        desc_pop = 1'b1;
        @(posedge clk);
        m_head++;
        #1 desc_pop = 1'b0;
    endtask

    function automatic logic [31:0] pat(int w, int p);
        return (32'h0102_0304 * (w * 16 + p + 1)) ^ 32'h5A3C_96E1;
    endfunction

    initial begin
        #(20 * 50000);
        if (!done) begin
            n_tests++; n_fail++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state
        check("R1 desc_valid", DW'(desc_valid), DW'(0));
        check("R1 fifo_full", DW'(fifo_full), DW'(0));
        check("R1 wait_req", DW'(wait_req), DW'(0));
        // R1/R4: commit with only the top byte shows the staging register was zero
        do_write(WORDS - 1, 32'h8000_0000, 4'b1000);
        pop_check("R1 R4 zero stage commit");

        // R2/R3/R4: sweep every byte-enable pattern with varied word order
        for (int p = 0; p < 16; p++) begin
            for (int k = 0; k < WORDS; k++) begin
                int w;
                w = (p % 2 == 0) ? (k + p) % WORDS : (WORDS - 1 - ((k + p) % WORDS));
                do_write(w, pat(w, p) & 32'h7FFF_FFFF, 4'(p));
            end
            do_write(0, pat(9, p), 4'(15 - p));
            do_write(WORDS - 1, pat(7, p) | 32'h8000_0000, 4'b1000 | 4'(p));
            pop_check("R2 R3 sweep");
        end

        // R5: non-commit writes to the top word
        do_write(WORDS - 1, 32'h7123_4567, 4'b1111);
        do_write(WORDS - 1, 32'hF0AA_BBCC, 4'b0111);
        @(negedge clk);
        check("R5 no push on low commit bit", DW'(desc_valid), DW'(0));
        do_write(1, 32'hDEAD_BEEF, 4'b0101);
        do_write(WORDS - 1, 32'h8000_0000, 4'b1000);
        pop_check("R5 staged bytes kept");

        // R6: staging cleared after commit
        do_write(2, 32'h1111_2222, 4'b1111);
        do_write(WORDS - 1, 32'hFFFF_FFFF, 4'b1111);
        do_write(WORDS - 1, 32'h8100_0000, 4'b1000);
        pop_check("R6 first");
        pop_check("R6 cleared");

        // R7/R8: fill the FIFO
        for (int i = 0; i < DEPTH; i++) begin
            do_write(0, 32'hA000_0000 + i, 4'b1111);
            do_write(WORDS - 1, 32'h8000_0010 + i, 4'b1001);
        end
        @(negedge clk);
        check("R8 fifo_full", DW'(fifo_full), DW'(1));
        // R9: non-commit write while full
        do_write(2, 32'h0BAD_F00D, 4'b1111);
        // R8: stalled commit
        @(negedge clk);
        wr_addr = 2'(WORDS - 1); wr_data = 32'h8765_4321; wr_be = 4'b1111; wr_en = 1'b1;
        for (int c = 0; c < 3; c++) begin
            #1;
            check("R8 wait_req held", DW'(wait_req), DW'(1));
            check("R8 head unchanged", desc_data, m_q[m_head % 32]);
            @(negedge clk);
        end
        check("R8 head before pop", desc_data, m_q[m_head % 32]);
        desc_pop = 1'b1;
        @(posedge clk);
        m_head++;
        @(negedge clk);
        desc_pop = 1'b0;
        #1;
        check("R8 wait released", DW'(wait_req), DW'(0));
        @(posedge clk);
        model_write(WORDS - 1, 32'h8765_4321, 4'b1111);
        #1 wr_en = 1'b0;
        @(negedge clk);
        check("R8 full again", DW'(fifo_full), DW'(1));
        for (int i = 0; i < DEPTH; i++) pop_check("R7 order");
        @(negedge clk);
        check("R7 empty", DW'(desc_valid), DW'(0));

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule